// File: doc/BRIEF.md
# Vertex Constant Store With Two Upload Paths

This block holds the vector constants read by a vertex processor. It stores 192 entries of four 32-bit dwords (X, Y, Z, W), indexed 0 to 191. The storage is split into two banks of 96 entries, and entries 96 to 191 make up the second bank. The shader datapath reads one entry per cycle through an 8-bit index. That index can be offset by a signed address register.

Two host paths load the store, and each sends one dword per cycle. A debug/indirect path sends an entry's components in the order W, Z, Y, X. The command-stream path sends them in the order X, Y, Z, W. Each path first selects a starting entry. It then sends dwords continuously: every fourth dword writes a whole entry and moves the path's pointer to the next entry.

Two mode inputs control access. The first makes the store read-only for the command stream. The second limits the shader to the low bank.

Top module: `vconst_mem`

## Requirements
- R1: After reset every entry holds zero, `rd_data` is zero and `rd_oor` is low.
- R2: On the indirect path, the four dwords following a select are the W, Z, Y and X components, in that order. `rd_data` packs X in [31:0], Y in [63:32], Z in [95:64] and W in [127:96].
- R3: On the command path, the four dwords following a select are the X, Y, Z and W components, in that order.
- R4: Each path keeps its own pointer and dword count. A select loads the pointer and discards any partly received entry. A select wins over a dword offered in the same cycle. An entry is written only on its fourth dword, and the pointer then advances by one. While the pointer is 192 or more, completed entries are discarded and the pointer holds.
- R5: While `ro_mode` is high, command-path dwords are ignored. Command-path selects and the whole indirect path keep working.
- R6: A read with `rd_en` high updates `rd_data` one cycle later, with the contents from before any write at that same edge. With `rd_en` low, `rd_data` holds.
- R7: When `rd_rel` is high, the effective index is `rd_idx` plus `rd_a0`, where `rd_a0` is an 8-bit two's-complement value. Otherwise the effective index is `rd_idx`.
- R8: While `low_only` is high, reads of effective indices 96 to 191 return zero and do not set `rd_oor`.
- R9: A read whose effective index is below 0 or above 191 returns zero and sets `rd_oor`. `rd_oor` then stays high until reset.
- R10: When both paths complete an entry in the same cycle, only the indirect entry is written. The command entry is lost, but the command pointer still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ro_mode | input | 1 | Command path read-only |
| low_only | input | 1 | Shader limited to entries 0..95 |
| dbg_sel_vld | input | 1 | Indirect path: load start entry |
| dbg_sel_idx | input | 8 | Indirect path: start entry |
| dbg_wr_vld | input | 1 | Indirect path: dword valid |
| dbg_wr_data | input | 32 | Indirect path: dword (W,Z,Y,X order) |
| cmd_sel_vld | input | 1 | Command path: load start entry |
| cmd_sel_idx | input | 8 | Command path: start entry |
| cmd_wr_vld | input | 1 | Command path: dword valid |
| cmd_wr_data | input | 32 | Command path: dword (X,Y,Z,W order) |
| rd_en | input | 1 | Shader read request |
| rd_idx | input | 8 | Shader instruction index |
| rd_rel | input | 1 | Add address register to index |
| rd_a0 | input | 8 | Address register, two's complement |
| rd_data | output | 128 | Entry read, X in low dword |
| rd_oor | output | 1 | Sticky out-of-range flag |

## Verification
The assertions check the following on every cycle:
- zero data for masked and out-of-range reads;
- the sticky flag never falling;
- read data holding while idle;
- at most one bank written;
- no command write in read-only mode;
- each path's pointer and count loading on a select and holding while idle.

Other behaviours depend on a sequence of stimulus, so only the bench scenarios can show them:
- the component ordering of each path;
- the pointer advancing across the bank boundary and stopping past entry 191;
- a partial entry being discarded by a new select;
- the read-before-write result;
- the arbitration outcome when both paths complete together.

// File: rtl/vconst_pkg.sv
package vconst_pkg;
  localparam int COMPS = 4;

  typedef enum logic {
    ORD_XYZW = 1'b0,
    ORD_WZYX = 1'b1
  } ord_e;
endpackage

// File: rtl/vconst_assembler.sv
module vconst_assembler
  import vconst_pkg::*;
#(
  parameter int   DW      = 32,
  parameter int   IDX_W   = 8,
  parameter int   NUM_ENT = 192,
  parameter ord_e ORDER   = ORD_XYZW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_vld,
  input  logic [IDX_W-1:0]      sel_idx,
  input  logic                  wr_vld,
  input  logic [DW-1:0]         wr_data,
  output logic                  commit,
  output logic [IDX_W-1:0]      commit_idx,
  output logic [COMPS*DW-1:0]   commit_vec
);
  localparam int CW = $clog2(COMPS);
  localparam logic [CW-1:0] LAST = CW'(COMPS - 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [DW-1:0]    stage_q [COMPS-1];
  logic [DW-1:0]    stage_d [COMPS-1];
  logic             last_dw;
  logic             ptr_ok;

  assign ptr_ok  = int'(ptr_q) < NUM_ENT;
  assign last_dw = wr_vld && !sel_vld && (cnt_q == LAST);

  always_comb begin
    cnt_d   = cnt_q;
    ptr_d   = ptr_q;
    stage_d = stage_q;
    if (sel_vld) begin
      cnt_d = '0;
      ptr_d = sel_idx;
    end else if (wr_vld) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        if (ptr_ok) ptr_d = ptr_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
        stage_d[cnt_q] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
      for (int i = 0; i < COMPS - 1; i++) stage_q[i] <= '0;
    end else begin
      cnt_q   <= cnt_d;
      ptr_q   <= ptr_d;
      stage_q <= stage_d;
    end
  end

  // arrival position k lands in component slot SLOT
  for (genvar k = 0; k < COMPS; k++) begin : g_slot
    localparam int SLOT = (ORDER == ORD_XYZW) ? k : (COMPS - 1 - k);
    if (k == COMPS - 1) begin : g_tail
      assign commit_vec[SLOT*DW +: DW] = wr_data;
    end else begin : g_body
      assign commit_vec[SLOT*DW +: DW] = stage_q[k];
    end
  end

  assign commit     = last_dw && ptr_ok;
  assign commit_idx = ptr_q;

  // R4
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld |=> (cnt_q == '0) && (ptr_q == $past(sel_idx)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_vld && !wr_vld) |=> $stable(cnt_q) && $stable(ptr_q));
endmodule

// File: rtl/vconst_bank.sv
module vconst_bank #(
  parameter int W     = 128,
  parameter int DEPTH = 96,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = (int'(raddr) < DEPTH) ? mem_q[raddr] : '0;

  // R4
  bank_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/vconst_rdindex.sv
module vconst_rdindex #(
  parameter int IDX_W   = 8,
  parameter int NUM_ENT = 192,
  parameter int LOW_ENT = 96
) (
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_rel,
  input  logic [IDX_W-1:0] rd_ofs,
  input  logic             low_only,
  output logic [IDX_W-1:0] eff_idx,
  output logic             in_range,
  output logic             masked
);
  localparam int SW = IDX_W + 2;

  logic signed [SW-1:0] base_s, ofs_s, sum_s;

  always_comb begin
    base_s   = $signed({2'b00, rd_idx});
    ofs_s    = rd_rel ? $signed({{2{rd_ofs[IDX_W-1]}}, rd_ofs}) : '0;
    sum_s    = base_s + ofs_s;
    in_range = !sum_s[SW-1] && (int'(sum_s) < NUM_ENT);
    eff_idx  = sum_s[IDX_W-1:0];
    masked   = low_only && in_range && (int'(eff_idx) >= LOW_ENT);
  end
endmodule

// File: rtl/vconst_mem.sv
module vconst_mem
  import vconst_pkg::*;
#(
  parameter int DW         = 32,
  parameter int IDX_W      = 8,
  parameter int BANK_DEPTH = 96,
  parameter int NUM_BANKS  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ro_mode,
  input  logic                 low_only,
  input  logic                 dbg_sel_vld,
  input  logic [IDX_W-1:0]     dbg_sel_idx,
  input  logic                 dbg_wr_vld,
  input  logic [DW-1:0]        dbg_wr_data,
  input  logic                 cmd_sel_vld,
  input  logic [IDX_W-1:0]     cmd_sel_idx,
  input  logic                 cmd_wr_vld,
  input  logic [DW-1:0]        cmd_wr_data,
  input  logic                 rd_en,
  input  logic [IDX_W-1:0]     rd_idx,
  input  logic                 rd_rel,
  input  logic [IDX_W-1:0]     rd_a0,
  output logic [COMPS*DW-1:0]  rd_data,
  output logic                 rd_oor
);
  localparam int NUM_ENT = NUM_BANKS * BANK_DEPTH;
  localparam int AW      = $clog2(BANK_DEPTH);
  localparam int VW      = COMPS * DW;

  // upload paths
  logic             dbg_commit, cmd_commit;
  logic [IDX_W-1:0] dbg_cidx, cmd_cidx;
  logic [VW-1:0]    dbg_cvec, cmd_cvec;
  logic             cmd_wr_gated;

  assign cmd_wr_gated = cmd_wr_vld && !ro_mode;

  vconst_assembler #(
    .DW(DW), .IDX_W(IDX_W), .NUM_ENT(NUM_ENT), .ORDER(ORD_WZYX)
  ) u_dbg_path (
    .clk(clk), .rst_n(rst_n),
    .sel_vld(dbg_sel_vld), .sel_idx(dbg_sel_idx),
    .wr_vld(dbg_wr_vld), .wr_data(dbg_wr_data),
    .commit(dbg_commit), .commit_idx(dbg_cidx), .commit_vec(dbg_cvec)
  );

  vconst_assembler #(
    .DW(DW), .IDX_W(IDX_W), .NUM_ENT(NUM_ENT), .ORDER(ORD_XYZW)
  ) u_cmd_path (
    .clk(clk), .rst_n(rst_n),
    .sel_vld(cmd_sel_vld), .sel_idx(cmd_sel_idx),
    .wr_vld(cmd_wr_gated), .wr_data(cmd_wr_data),
    .commit(cmd_commit), .commit_idx(cmd_cidx), .commit_vec(cmd_cvec)
  );

  // single write port: indirect path first
  logic             w_any;
  logic [IDX_W-1:0] w_idx;
  logic [VW-1:0]    w_vec;

  always_comb begin
    w_any = dbg_commit || cmd_commit;
    w_idx = dbg_commit ? dbg_cidx : cmd_cidx;
    w_vec = dbg_commit ? dbg_cvec : cmd_cvec;
  end

  // read index
  logic [IDX_W-1:0] eff_idx;
  logic             eff_ok, eff_masked;

  vconst_rdindex #(
    .IDX_W(IDX_W), .NUM_ENT(NUM_ENT), .LOW_ENT(BANK_DEPTH)
  ) u_rdindex (
    .rd_idx(rd_idx), .rd_rel(rd_rel), .rd_ofs(rd_a0), .low_only(low_only),
    .eff_idx(eff_idx), .in_range(eff_ok), .masked(eff_masked)
  );

  // banks
  logic [NUM_BANKS-1:0] bank_we;
  logic [NUM_BANKS-1:0] bank_rhit;
  logic [VW-1:0]        bank_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BASE = b * BANK_DEPTH;
    logic [AW-1:0] waddr, raddr;

    assign bank_we[b]   = w_any && (int'(w_idx) >= BASE) && (int'(w_idx) < BASE + BANK_DEPTH);
    assign bank_rhit[b] = (int'(eff_idx) >= BASE) && (int'(eff_idx) < BASE + BANK_DEPTH);
    assign waddr        = AW'(int'(w_idx) - BASE);
    assign raddr        = AW'(int'(eff_idx) - BASE);

    vconst_bank #(.W(VW), .DEPTH(BANK_DEPTH), .AW(AW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(bank_we[b]), .waddr(waddr), .wdata(w_vec),
      .raddr(raddr), .rdata(bank_rd[b])
    );
  end

  logic [VW-1:0] rd_vec;

  always_comb begin
    rd_vec = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_rhit[b]) rd_vec = bank_rd[b];
    end
  end

  // output registers
  logic [VW-1:0] rd_data_q, rd_data_d;
  logic          oor_q, oor_d;

  always_comb begin
    rd_data_d = rd_data_q;
    oor_d     = oor_q;
    if (rd_en) begin
      rd_data_d = (!eff_ok || eff_masked) ? '0 : rd_vec;
      oor_d     = oor_q || !eff_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
      oor_q     <= 1'b0;
    end else begin
      rd_data_q <= rd_data_d;
      oor_q     <= oor_d;
    end
  end

  assign rd_data = rd_data_q;
  assign rd_oor  = oor_q;

  // R9
  oor_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oor |=> rd_oor);

  // R9
  oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !eff_ok) |=> (rd_oor && (rd_data == '0)));

  // R8
  low_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && low_only && eff_ok && (int'(eff_idx) >= BANK_DEPTH)) |=> (rd_data == '0));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R10
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  // R5
  ro_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_mode |-> !cmd_commit);
endmodule

// File: tb/vconst_mem_test.sv
module vconst_mem_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ro_mode = 1'b0, low_only = 1'b0;
  logic         dbg_sel_vld = 1'b0, dbg_wr_vld = 1'b0;
  logic [7:0]   dbg_sel_idx = '0;
  logic [31:0]  dbg_wr_data = '0;
  logic         cmd_sel_vld = 1'b0, cmd_wr_vld = 1'b0;
  logic [7:0]   cmd_sel_idx = '0;
  logic [31:0]  cmd_wr_data = '0;
  logic         rd_en = 1'b0, rd_rel = 1'b0;
  logic [7:0]   rd_idx = '0, rd_a0 = '0;
  logic [127:0] rd_data;
  logic         rd_oor;

  always #(CLK_PERIOD/2) clk = ~clk;

  vconst_mem uut (
    .clk(clk), .rst_n(rst_n), .ro_mode(ro_mode), .low_only(low_only),
    .dbg_sel_vld(dbg_sel_vld), .dbg_sel_idx(dbg_sel_idx),
    .dbg_wr_vld(dbg_wr_vld), .dbg_wr_data(dbg_wr_data),
    .cmd_sel_vld(cmd_sel_vld), .cmd_sel_idx(cmd_sel_idx),
    .cmd_wr_vld(cmd_wr_vld), .cmd_wr_data(cmd_wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_rel(rd_rel), .rd_a0(rd_a0),
    .rd_data(rd_data), .rd_oor(rd_oor)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference model
  logic [31:0]  mem [192][4];
  logic [31:0]  dq[$];
  logic [31:0]  cq[$];
  int           dptr = 0, cptr = 0;
  logic [127:0] exp_data = '0;
  logic         exp_oor = 1'b0;

  always @(posedge clk) begin
    int          eff;
    bit          dc, cc;
    int          di, ci;
    logic [31:0] dv[4];
    logic [31:0] cv[4];
    if (!rst_n) begin
      for (int i = 0; i < 192; i++) for (int c = 0; c < 4; c++) mem[i][c] = '0;
      dq.delete(); cq.delete(); dptr = 0; cptr = 0;
      exp_data = '0; exp_oor = 1'b0;
    end else begin
      if (rd_en) begin
        eff = int'(rd_idx);
        if (rd_rel) eff = eff + int'($signed(rd_a0));
        if (eff < 0 || eff > 191) begin
          exp_data = '0; exp_oor = 1'b1;
        end else if (low_only && eff >= 96) begin
          exp_data = '0;
        end else begin
          exp_data = {mem[eff][3], mem[eff][2], mem[eff][1], mem[eff][0]};
        end
      end
      dc = 0; cc = 0; di = 0; ci = 0;
      if (dbg_sel_vld) begin
        dq.delete(); dptr = int'(dbg_sel_idx);
      end else if (dbg_wr_vld) begin
        dq.push_back(dbg_wr_data);
        if (dq.size() == 4) begin
          if (dptr < 192) begin
            dc = 1; di = dptr;
            dv[0] = dq[3]; dv[1] = dq[2]; dv[2] = dq[1]; dv[3] = dq[0];
            dptr++;
          end
          dq.delete();
        end
      end
      if (cmd_sel_vld) begin
        cq.delete(); cptr = int'(cmd_sel_idx);
      end else if (cmd_wr_vld && !ro_mode) begin
        cq.push_back(cmd_wr_data);
        if (cq.size() == 4) begin
          if (cptr < 192) begin
            cc = 1; ci = cptr;
            for (int c = 0; c < 4; c++) cv[c] = cq[c];
            cptr++;
          end
          cq.delete();
        end
      end
      if (dc) for (int c = 0; c < 4; c++) mem[di][c] = dv[c];
      else if (cc) for (int c = 0; c < 4; c++) mem[ci][c] = cv[c];
    end
  end

  function automatic logic [127:0] v4(input logic [31:0] x, y, z, w);
    return {w, z, y, x};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock; compare against the model away from the edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) begin
      chk({cur_req, " rd_data/model"}, rd_data, exp_data);
      chk({cur_req, " rd_oor/model"}, {127'd0, rd_oor}, {127'd0, exp_oor});
    end
  endtask

  task automatic dbg_sel(input int idx);
    dbg_sel_vld = 1; dbg_sel_idx = 8'(idx); tick(); dbg_sel_vld = 0;
  endtask

  task automatic cmd_sel(input int idx);
    cmd_sel_vld = 1; cmd_sel_idx = 8'(idx); tick(); cmd_sel_vld = 0;
  endtask

  task automatic dbg_dw(input logic [31:0] d);
    dbg_wr_vld = 1; dbg_wr_data = d; tick(); dbg_wr_vld = 0;
  endtask

  task automatic cmd_dw(input logic [31:0] d);
    cmd_wr_vld = 1; cmd_wr_data = d; tick(); cmd_wr_vld = 0;
  endtask

  task automatic rd(input int idx, input bit rel, input int a0);
    rd_en = 1; rd_idx = 8'(idx); rd_rel = rel; rd_a0 = 8'(a0);
    tick();
    rd_en = 0; rd_rel = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R1";
    chk("R1 reset data", rd_data, '0);
    chk("R1 reset oor", {127'd0, rd_oor}, '0);
    rd(5, 0, 0);
    chk("R1 entry zero", rd_data, '0);

    cur_req = "R2";
    dbg_sel(0);
    dbg_dw(32'h14); dbg_dw(32'h13); dbg_dw(32'h12); dbg_dw(32'h11);
    rd(0, 0, 0);
    chk("R2 wzyx order", rd_data, v4(32'h11, 32'h12, 32'h13, 32'h14));

    cur_req = "R3";
    cmd_sel(95);
    for (int e = 0; e < 3; e++)
      for (int c = 0; c < 4; c++) cmd_dw(32'h100 * (e + 1) + 32'(c));
    rd(95, 0, 0);
    chk("R3 xyzw order", rd_data, v4(32'h100, 32'h101, 32'h102, 32'h103));
    cur_req = "R4";
    rd(96, 0, 0);
    chk("R4 autoinc bank edge", rd_data, v4(32'h200, 32'h201, 32'h202, 32'h203));
    rd(97, 0, 0);
    chk("R4 autoinc third", rd_data, v4(32'h300, 32'h301, 32'h302, 32'h303));

    cmd_sel(10);
    cmd_dw(32'hAA); cmd_dw(32'hBB);
    cmd_sel(20);
    for (int c = 0; c < 4; c++) cmd_dw(32'h20 + 32'(c));
    rd(10, 0, 0);
    chk("R4 partial discarded", rd_data, '0);
    rd(20, 0, 0);
    chk("R4 reselect", rd_data, v4(32'h20, 32'h21, 32'h22, 32'h23));

    cmd_sel_vld = 1; cmd_sel_idx = 8'd22; cmd_wr_vld = 1; cmd_wr_data = 32'hDEAD;
    tick();
    cmd_sel_vld = 0;
    for (int c = 0; c < 4; c++) begin
      cmd_wr_data = 32'h70 + 32'(c); tick();
    end
    cmd_wr_vld = 0;
    rd(22, 0, 0);
    chk("R4 select beats dword", rd_data, v4(32'h70, 32'h71, 32'h72, 32'h73));

    dbg_sel(191);
    for (int c = 0; c < 4; c++) dbg_dw(32'h91 + 32'(c));
    for (int c = 0; c < 4; c++) dbg_dw(32'hEE);
    rd(191, 0, 0);
    chk("R4 last entry", rd_data, v4(32'h94, 32'h93, 32'h92, 32'h91));
    rd(0, 0, 0);
    chk("R4 past end dropped", rd_data, v4(32'h11, 32'h12, 32'h13, 32'h14));

    cur_req = "R5";
    ro_mode = 1;
    cmd_sel(30);
    for (int c = 0; c < 4; c++) cmd_dw(32'h30 + 32'(c));
    dbg_sel(31);
    for (int c = 0; c < 4; c++) dbg_dw(32'h40 + 32'(c));
    ro_mode = 0;
    rd(30, 0, 0);
    chk("R5 cmd dropped", rd_data, '0);
    rd(31, 0, 0);
    chk("R5 dbg still writes", rd_data, v4(32'h43, 32'h42, 32'h41, 32'h40));

    cur_req = "R6";
    dbg_sel(40);
    dbg_dw(32'h5); dbg_dw(32'h6); dbg_dw(32'h7);
    dbg_wr_vld = 1; dbg_wr_data = 32'h8;
    rd_en = 1; rd_idx = 8'd40;
    tick();
    dbg_wr_vld = 0; rd_en = 0;
    chk("R6 read before write", rd_data, '0);
    rd(40, 0, 0);
    rd_idx = 8'd31;
    tick(); tick();
    chk("R6 idle hold", rd_data, v4(32'h8, 32'h7, 32'h6, 32'h5));

    cur_req = "R7";
    rd(100, 1, -5);
    chk("R7 negative offset", rd_data, v4(32'h100, 32'h101, 32'h102, 32'h103));
    rd(190, 1, 1);
    chk("R7 positive offset", rd_data, v4(32'h94, 32'h93, 32'h92, 32'h91));

    cur_req = "R8";
    low_only = 1;
    rd(96, 0, 0);
    chk("R8 high masked", rd_data, '0);
    chk("R8 no flag", {127'd0, rd_oor}, '0);
    rd(95, 0, 0);
    chk("R8 low visible", rd_data, v4(32'h100, 32'h101, 32'h102, 32'h103));
    low_only = 0;

    cur_req = "R10";
    dbg_sel_vld = 1; dbg_sel_idx = 8'd50; cmd_sel_vld = 1; cmd_sel_idx = 8'd50;
    tick();
    dbg_sel_vld = 0; cmd_sel_vld = 0;
    for (int c = 0; c < 4; c++) begin
      dbg_wr_vld = 1; dbg_wr_data = 32'hD0 + 32'(c);
      cmd_wr_vld = 1; cmd_wr_data = 32'hC0 + 32'(c);
      tick();
    end
    dbg_wr_vld = 0;
    for (int c = 0; c < 4; c++) begin
      cmd_wr_data = 32'hE0 + 32'(c); tick();
    end
    cmd_wr_vld = 0;
    rd(50, 0, 0);
    chk("R10 indirect wins", rd_data, v4(32'hD3, 32'hD2, 32'hD1, 32'hD0));
    rd(51, 0, 0);
    chk("R10 cmd pointer advanced", rd_data, v4(32'hE0, 32'hE1, 32'hE2, 32'hE3));

    cur_req = "R9";
    rd(200, 0, 0);
    chk("R9 high oor data", rd_data, '0);
    chk("R9 high oor flag", {127'd0, rd_oor}, 128'd1);
    rd(0, 0, 0);
    chk("R9 sticky", {127'd0, rd_oor}, 128'd1);
    rd(2, 1, -3);
    chk("R9 negative oor", rd_data, '0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule